// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block keeps the time of day and the calendar date as packed BCD fields: hundredths of a second, seconds, minutes, hours in 24-hour form, a 3-bit day of week, the day of the month, the month, the two-digit year and a single century bit. It advances by one hundredth of a second for every `TICK_DIV` cycles in which the tick enable is high. Each carry ripples up the chain of fields in the same clock cycle. The end of each month is worked out from the current month and year, so short months and leap-year Februaries roll over on the correct day.

Software-side logic loads the fields one at a time through a shared data byte and a one-hot write-enable vector. A write to the hundredths field always stores 00. Any write also restarts the tick prescaler, so the next hundredth begins a full period after the load. A stop input freezes all counting. A century-enable input decides whether the century bit flips when the year wraps.

Top module: `rtc_calendar`

## Requirements
- R1: After a synchronous reset the outputs read 00:00:00.00, day of week 1, date 01, month 01, year 00, century bit 0.
- R2: With `TICK_DIV` = N, every N cycles of tick high (stop low, no write) advance the hundredths by one in BCD. The low digit carries from 9 into the high digit. 99 wraps to 00 and advances the seconds by one.
- R3: Seconds and minutes count 00 to 59, and each wraps to 00 while advancing the next field. Hours count 00 to 23, and the wrap from 23 to 00 advances the day.
- R4: When the day advances, the day of week (the low 3 bits of its field) counts 1 to 7, then wraps from 7 to 1. The date advances on the same cycle.
- R5: The date wraps to 01 and advances the month after 30 in months 04, 06, 09 and 11, after 31 in the other long months, and after 28 in a February of a non-leap year.
- R6: A February has 29 days when the BCD year is divisible by four, including year 00.
- R7: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00.
- R8: On a 99-to-00 year wrap the century bit inverts when century-enable is 1 and holds when it is 0. Write-enable bit 8 loads the century bit from data bit 0.
- R9: While stop is 1, tick pulses have no effect and no field changes. Once stop returns to 0, counting resumes from the held state and prescaler phase.
- R10: A write to the hundredths field (write-enable bit 0) stores 00 whatever the data byte holds.
- R11: Write-enable bits select fields 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 day of week, 5 date, 6 month, 7 year, 8 century. A cycle with any write bit set clears the prescaler phase and advances no field, even with tick high.
- R12: A write to the day-of-week field keeps only data bits 2:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Single-cycle count enable from the slow time base |
| stop | input | 1 | Freeze all counting while high |
| cent_en | input | 1 | Allow the century bit to flip on year wrap |
| wr_en | input | 9 | One-hot field write strobes (bit map in R11) |
| wr_data | input | 8 | Shared BCD write data |
| hsec_o | output | 8 | Hundredths of a second, BCD 00-99 |
| sec_o | output | 8 | Seconds, BCD 00-59 |
| min_o | output | 8 | Minutes, BCD 00-59 |
| hour_o | output | 8 | Hours, BCD 00-23 |
| dow_o | output | 3 | Day of week, 1-7 |
| date_o | output | 8 | Day of month, BCD 01-31 |
| month_o | output | 8 | Month, BCD 01-12 |
| year_o | output | 8 | Year, BCD 00-99 |
| cent_o | output | 1 | Century bit |

## Verification
The bench builds the block with `TICK_DIV` = 2. With that value a single tick cycle leaves the prescaler half-way through a hundredth, so the bench can show that a write discards that partial phase and that stop holds it. The default value of 1 would make a tick and a hundredth the same thing and hide both effects. Each rollover case loads its fields just below a boundary, so one hundred hundredths are enough to cross a day, month, year or century edge.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int NUM_FIELDS = 8;
    localparam int F_HSEC  = 0;
    localparam int F_SEC   = 1;
    localparam int F_MIN   = 2;
    localparam int F_HOUR  = 3;
    localparam int F_DOW   = 4;
    localparam int F_DATE  = 5;
    localparam int F_MONTH = 6;
    localparam int F_YEAR  = 7;
    localparam int W_CENT  = NUM_FIELDS;
    localparam int WR_BITS = NUM_FIELDS + 1;

    typedef logic [7:0] bcd8_t;

    typedef struct packed {
        bcd8_t [NUM_FIELDS-1:0] fld;
        logic                   cent;
    } cal_state_t;

    // fld[7] year .. fld[0] hundredths
    localparam cal_state_t CAL_RESET = '{
        fld:  {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00},
        cent: 1'b0
    };

    function automatic bcd8_t bcd_inc(bcd8_t v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic bcd8_t field_lo(int idx);
        if (idx == F_DOW || idx == F_DATE || idx == F_MONTH) return 8'h01;
        return 8'h00;
    endfunction

    function automatic bcd8_t field_hi(int idx);
        case (idx)
            F_HSEC:  return 8'h99;
            F_SEC:   return 8'h59;
            F_MIN:   return 8'h59;
            F_HOUR:  return 8'h23;
            F_DOW:   return 8'h07;
            F_MONTH: return 8'h12;
            F_YEAR:  return 8'h99;
            default: return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_tick_prescaler.sv
module rtc_tick_prescaler #(
    parameter int TICK_DIV = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    output logic adv
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'((TICK_DIV > 1) ? TICK_DIV - 1 : 0);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          at_last;

    always_comb begin
        at_last = (cnt_q == LAST);
        cnt_d   = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (run)
            cnt_d = at_last ? '0 : cnt_q + CW'(1);
        adv = run & ~clr & at_last;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rtc_bcd_step.sv
module rtc_bcd_step
    import rtc_cal_pkg::*;
(
    input  bcd8_t cur,
    input  bcd8_t lo,
    input  bcd8_t hi,
    output bcd8_t nxt,
    output logic  wrap
);
    // >= rather than == so an out-of-range load still wraps
    always_comb begin
        wrap = (cur >= hi);
        nxt  = wrap ? lo : bcd_inc(cur);
    end
endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len
    import rtc_cal_pkg::*;
(
    input  bcd8_t month,
    input  bcd8_t year,
    output bcd8_t last
);
    logic [6:0] year_bin;
    logic       leap;

    always_comb begin
        year_bin = {3'b000, year[7:4]} * 7'd10 + {3'b000, year[3:0]};
        leap     = ((year_bin % 7'd4) == 7'd0);
        case (month)
            8'h02:                      last = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last = 8'h30;
            default:                    last = 8'h31;
        endcase
    end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_cal_pkg::*;
#(
    parameter int TICK_DIV = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               stop,
    input  logic               cent_en,
    input  logic [WR_BITS-1:0] wr_en,
    input  logic [7:0]         wr_data,
    output logic [7:0]         hsec_o,
    output logic [7:0]         sec_o,
    output logic [7:0]         min_o,
    output logic [7:0]         hour_o,
    output logic [2:0]         dow_o,
    output logic [7:0]         date_o,
    output logic [7:0]         month_o,
    output logic [7:0]         year_o,
    output logic               cent_o
);
    cal_state_t            st_d, st_q;
    logic                  any_wr;
    logic                  adv;
    bcd8_t                 last_date;
    bcd8_t                 lo  [NUM_FIELDS];
    bcd8_t                 hi  [NUM_FIELDS];
    bcd8_t                 nxt [NUM_FIELDS];
    logic [NUM_FIELDS-1:0] wrap;
    logic [NUM_FIELDS-1:0] step;
    logic                  cent_flip;

    assign any_wr = |wr_en;

    rtc_tick_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
        .clk (clk),
        .rst (rst),
        .clr (any_wr),
        .run (tick & ~stop),
        .adv (adv)
    );

    rtc_month_len u_mlen (
        .month (st_q.fld[F_MONTH]),
        .year  (st_q.fld[F_YEAR]),
        .last  (last_date)
    );

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
        if (g == F_DATE) begin : g_var
            assign hi[g] = last_date;
        end else begin : g_fix
            assign hi[g] = field_hi(g);
        end
        assign lo[g] = field_lo(g);

        rtc_bcd_step u_step (
            .cur  (st_q.fld[g]),
            .lo   (lo[g]),
            .hi   (hi[g]),
            .nxt  (nxt[g]),
            .wrap (wrap[g])
        );
    end

    always_comb begin
        logic carry;
        carry = adv;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            step[i] = carry;
            // day of week runs beside the date, it never feeds the month
            if (i != F_DOW) carry = carry & wrap[i];
        end
        cent_flip = carry & cent_en;

        st_d = st_q;
        for (int i = 0; i < NUM_FIELDS; i++)
            if (step[i]) st_d.fld[i] = nxt[i];
        if (cent_flip) st_d.cent = ~st_q.cent;

        for (int i = 0; i < NUM_FIELDS; i++) begin
            if (wr_en[i]) begin
                if (i == F_HSEC)     st_d.fld[i] = 8'h00;
                else if (i == F_DOW) st_d.fld[i] = {5'b00000, wr_data[2:0]};
                else                 st_d.fld[i] = wr_data;
            end
        end
        if (wr_en[W_CENT]) st_d.cent = wr_data[0];
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= CAL_RESET;
        else     st_q <= st_d;
    end

    assign hsec_o  = st_q.fld[F_HSEC];
    assign sec_o   = st_q.fld[F_SEC];
    assign min_o   = st_q.fld[F_MIN];
    assign hour_o  = st_q.fld[F_HOUR];
    assign dow_o   = st_q.fld[F_DOW][2:0];
    assign date_o  = st_q.fld[F_DATE];
    assign month_o = st_q.fld[F_MONTH];
    assign year_o  = st_q.fld[F_YEAR];
    assign cent_o  = st_q.cent;
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
    import rtc_cal_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               stop,
    input logic               cent_en,
    input logic [WR_BITS-1:0] wr_en,
    input logic [7:0]         hsec_o,
    input logic [7:0]         sec_o,
    input logic [7:0]         min_o,
    input logic [7:0]         hour_o,
    input logic [2:0]         dow_o,
    input logic [7:0]         date_o,
    input logic [7:0]         month_o,
    input logic [7:0]         year_o,
    input logic               cent_o
);
    p_stop_freeze_r9: assert property (@(posedge clk) disable iff (rst)
        (stop && !(|wr_en)) |=> $stable({hsec_o, sec_o, min_o, hour_o, dow_o,
                                         date_o, month_o, year_o, cent_o}));

    p_hsec_write_zero_r10: assert property (@(posedge clk) disable iff (rst)
        wr_en[F_HSEC] |=> (hsec_o == 8'h00));

    p_write_no_count_r11: assert property (@(posedge clk) disable iff (rst)
        ((|wr_en) && !wr_en[F_HSEC]) |=> $stable(hsec_o));

    p_hour_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (hour_o == 8'h23 && !wr_en[F_HOUR]) |=> (hour_o == 8'h23 || hour_o == 8'h00));

    p_dow_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (dow_o == 3'd7 && !wr_en[F_DOW]) |=> (dow_o == 3'd7 || dow_o == 3'd1));

    p_month_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        (month_o == 8'h12 && !wr_en[F_MONTH]) |=> (month_o == 8'h12 || month_o == 8'h01));

    p_cent_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!cent_en && !wr_en[W_CENT]) |=> $stable(cent_o));
endmodule

bind rtc_calendar rtc_calendar_chk u_chk (.*);

// File: tb/rtc_calendar_bench.sv
module rtc_calendar_bench;
    import rtc_cal_pkg::*;

    localparam int TDIV = 2;
    localparam int NVEC = 15;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               tick = 1'b0;
    logic               stop = 1'b0;
    logic               cent_en = 1'b0;
    logic [WR_BITS-1:0] wr_en = '0;
    logic [7:0]         wr_data = 8'h00;
    logic [7:0]         hsec_o, sec_o, min_o, hour_o, date_o, month_o, year_o;
    logic [2:0]         dow_o;
    logic               cent_o;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    rtc_calendar #(.TICK_DIV(TDIV)) u_rtc_calendar (
        .clk(clk), .rst(rst), .tick(tick), .stop(stop), .cent_en(cent_en),
        .wr_en(wr_en), .wr_data(wr_data),
        .hsec_o(hsec_o), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
        .dow_o(dow_o), .date_o(date_o), .month_o(month_o), .year_o(year_o),
        .cent_o(cent_o)
    );

    typedef struct packed {
        logic [7:0]  sec, min, hour;
        logic [2:0]  dow;
        logic [7:0]  date, month, year;
        logic        cent, cen;
        logic [15:0] ticks;
        logic [7:0]  e_hsec, e_sec, e_min, e_hour;
        logic [2:0]  e_dow;
        logic [7:0]  e_date, e_month, e_year;
        logic        e_cent;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        // R2 plain hundredths
        '{8'h00,8'h00,8'h00,3'd1,8'h01,8'h01,8'h00,1'b0,1'b0,16'd5,
          8'h05,8'h00,8'h00,8'h00,3'd1,8'h01,8'h01,8'h00,1'b0},
        // R3 second into minute
        '{8'h59,8'h34,8'h12,3'd2,8'h15,8'h06,8'h10,1'b0,1'b0,16'd100,
          8'h00,8'h00,8'h35,8'h12,3'd2,8'h15,8'h06,8'h10,1'b0},
        // R2 BCD digit carry 09 -> 10 via hundredths wrap
        '{8'h09,8'h00,8'h00,3'd1,8'h01,8'h01,8'h00,1'b0,1'b0,16'd100,
          8'h00,8'h10,8'h00,8'h00,3'd1,8'h01,8'h01,8'h00,1'b0},
        // R3 minute into hour
        '{8'h59,8'h59,8'h00,3'd1,8'h01,8'h01,8'h00,1'b0,1'b0,16'd100,
          8'h00,8'h00,8'h00,8'h01,3'd1,8'h01,8'h01,8'h00,1'b0},
        // R8 century flips 0 -> 1 with enable
        '{8'h59,8'h59,8'h23,3'd7,8'h31,8'h12,8'h99,1'b0,1'b1,16'd100,
          8'h00,8'h00,8'h00,8'h00,3'd1,8'h01,8'h01,8'h00,1'b1},
        // R8 century holds without enable
        '{8'h59,8'h59,8'h23,3'd7,8'h31,8'h12,8'h99,1'b0,1'b0,16'd100,
          8'h00,8'h00,8'h00,8'h00,3'd1,8'h01,8'h01,8'h00,1'b0},
        // R8 century flips 1 -> 0 with enable
        '{8'h59,8'h59,8'h23,3'd7,8'h31,8'h12,8'h99,1'b1,1'b1,16'd100,
          8'h00,8'h00,8'h00,8'h00,3'd1,8'h01,8'h01,8'h00,1'b0},
        // R6 leap February 28 -> 29
        '{8'h59,8'h59,8'h23,3'd3,8'h28,8'h02,8'h24,1'b0,1'b0,16'd100,
          8'h00,8'h00,8'h00,8'h00,3'd4,8'h29,8'h02,8'h24,1'b0},
        // R5 plain February 28 -> March 01
        '{8'h59,8'h59,8'h23,3'd3,8'h28,8'h02,8'h23,1'b0,1'b0,16'd100,
          8'h00,8'h00,8'h00,8'h00,3'd4,8'h01,8'h03,8'h23,1'b0},
        // R6 year 00 February 29 -> March 01
        '{8'h59,8'h59,8'h23,3'd2,8'h29,8'h02,8'h00,1'b0,1'b0,16'd100,
          8'h00,8'h00,8'h00,8'h00,3'd3,8'h01,8'h03,8'h00,1'b0},
        // R5 30-day month wraps after 30
        '{8'h59,8'h59,8'h23,3'd5,8'h30,8'h04,8'h21,1'b0,1'b0,16'd100,
          8'h00,8'h00,8'h00,8'h00,3'd6,8'h01,8'h05,8'h21,1'b0},
        // R5 31-day month continues to 31
        '{8'h59,8'h59,8'h23,3'd5,8'h30,8'h05,8'h21,1'b0,1'b0,16'd100,
          8'h00,8'h00,8'h00,8'h00,3'd6,8'h31,8'h05,8'h21,1'b0},
        // R7 December into January, year +1
        '{8'h59,8'h59,8'h23,3'd6,8'h31,8'h12,8'h45,1'b0,1'b0,16'd100,
          8'h00,8'h00,8'h00,8'h00,3'd7,8'h01,8'h01,8'h46,1'b0},
        // R3 hour 22 -> 23, date untouched
        '{8'h59,8'h59,8'h22,3'd4,8'h10,8'h10,8'h10,1'b0,1'b0,16'd100,
          8'h00,8'h00,8'h00,8'h23,3'd4,8'h10,8'h10,8'h10,1'b0},
        // R4 day of week 7 -> 1 with date advance
        '{8'h59,8'h59,8'h23,3'd7,8'h31,8'h01,8'h05,1'b0,1'b0,16'd100,
          8'h00,8'h00,8'h00,8'h00,3'd1,8'h01,8'h02,8'h05,1'b0}
    };

    function automatic string vec_tag(int i);
        case (i)
            0, 2:           return "R2";
            1, 3, 13:       return "R3";
            4, 5, 6:        return "R8";
            7, 9:           return "R6";
            8, 10, 11:      return "R5";
            12:             return "R7";
            default:        return "R4";
        endcase
    endfunction

    function automatic logic [67:0] pack_st(logic [7:0] hs, logic [7:0] s, logic [7:0] m,
                                           logic [7:0] h, logic [2:0] dw, logic [7:0] dt,
                                           logic [7:0] mo, logic [7:0] yr, logic c);
        return {hs, s, m, h, dw, dt, mo, yr, c};
    endfunction

    function automatic logic [67:0] now_st();
        return pack_st(hsec_o, sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o, cent_o);
    endfunction

    task automatic check(input string tag, input logic [67:0] got, input logic [67:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [7:0] d);
        wr_en        = '0;
        wr_en[idx]   = 1'b1;
        wr_data      = d;
        @(negedge clk);
        wr_en        = '0;
    endtask

    task automatic run_ticks(input int n);
        if (n > 0) begin
            tick = 1'b1;
            repeat (n) @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic load(input vec_t v);
        wr(F_HSEC, 8'h5A);
        wr(F_SEC, v.sec);
        wr(F_MIN, v.min);
        wr(F_HOUR, v.hour);
        wr(F_DOW, {5'b00000, v.dow});
        wr(F_DATE, v.date);
        wr(F_MONTH, v.month);
        wr(F_YEAR, v.year);
        wr(W_CENT, {7'b0000000, v.cent});
        cent_en = v.cen;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [67:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", now_st(), pack_st(8'h00,8'h00,8'h00,8'h00,3'd1,8'h01,8'h01,8'h00,1'b0));

        for (int i = 0; i < NVEC; i++) begin
            load(VECS[i]);
            run_ticks(TDIV * int'(VECS[i].ticks));
            check(vec_tag(i), now_st(),
                  pack_st(VECS[i].e_hsec, VECS[i].e_sec, VECS[i].e_min, VECS[i].e_hour,
                          VECS[i].e_dow, VECS[i].e_date, VECS[i].e_month, VECS[i].e_year,
                          VECS[i].e_cent));
        end
        cent_en = 1'b0;

        // R10: hundredths load stores 00 whatever the data
        load(VECS[0]);
        run_ticks(TDIV * 3);
        check("R10", {60'd0, hsec_o}, {60'd0, 8'h03});
        wr(F_HSEC, 8'h47);
        check("R10", {60'd0, hsec_o}, {60'd0, 8'h00});

        // R11: a write discards the half-finished prescaler phase
        run_ticks(1);
        wr(F_SEC, 8'h20);
        run_ticks(1);
        check("R11", {52'd0, sec_o, hsec_o}, {52'd0, 8'h20, 8'h00});
        run_ticks(1);
        check("R11", {60'd0, hsec_o}, {60'd0, 8'h01});

        // R11: writes with tick high advance nothing
        tick = 1'b1;
        for (int k = 0; k < 4; k++) wr(F_MIN, 8'h41);
        tick = 1'b0;
        check("R11", {52'd0, min_o, hsec_o}, {52'd0, 8'h41, 8'h01});

        // R9: stop freezes everything, including prescaler phase
        run_ticks(1);
        held = now_st();
        stop = 1'b1;
        run_ticks(40);
        check("R9", now_st(), held);
        stop = 1'b0;
        run_ticks(1);
        check("R9", {60'd0, hsec_o}, {60'd0, 8'h02});

        // R12: day-of-week write keeps bits 2:0
        wr(F_DOW, 8'hFD);
        check("R12", {65'd0, dow_o}, {65'd0, 3'd5});

        // R8: century write through bit 8, data bit 0
        wr(W_CENT, 8'hFF);
        check("R8", {67'd0, cent_o}, {67'd0, 1'b1});
        wr(W_CENT, 8'hFE);
        check("R8", {67'd0, cent_o}, {67'd0, 1'b0});

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule